// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port

This block is the serial test port of a synchronous memory device. It runs on its own test clock and tracks the standard sixteen-state test controller from a mode-select input. It moves serial data from a data-in pin to a data-out pin through one register at a time. The register in that path is picked by a three-bit instruction. The port has a one-bit pass-through register, a 32-bit device identity register and a boundary register whose length is a parameter. No signal of the port reaches the memory's own datapath, so test activity and test resets leave normal operation untouched.

The port is deliberately partial. It implements only identity readout, pass-through and pin sampling with preload. This keeps logic off the memory's critical path. It still behaves like any other test port on a shared chain. Data enters at the most significant bit of the selected register and leaves from the least significant bit. Inputs are taken on the rising test-clock edge. The data-out pin and its enable change only on the falling edge. The enable is active only while a register is shifting.

Top module: `scan_port`

## Requirements
- R1: While `por_n` is low and after its release with `tms` high, `tdo_oe` is 0, `bsr_po` is all zeros and the active instruction is the identity code.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR, and it changes only on the falling edge of `tck`.
- R4: In Capture-IR the instruction shift register loads 3'b001, so the first three bits shifted out of an IR scan are 1, 0, 0.
- R5: Instruction codes are 3'b001 identity, 3'b100 sample/preload and 3'b111 pass-through. Every other code behaves as pass-through. The active instruction changes only on leaving Update-IR or Test-Logic-Reset.
- R6: With pass-through selected, Capture-DR loads 0 into the one-bit register, and `tdo` reproduces `tdi` one shift later.
- R7: With identity selected, Capture-DR loads the 32-bit `ID_CODE` parameter with bit 0 forced to 1, shifted out LSB first.
- R8: With sample/preload selected, Capture-DR loads `bsr_pi`, and leaving Update-DR copies the shift register (bit 0 = first bit shifted in last position from LSB) into `bsr_po`. `bsr_po` changes at no other time.
- R9: `tdi` enters the most significant bit of the selected register, and `tdo` shows its least significant bit during shift states.
- R10: In Test-Logic-Reset the active instruction is forced to the identity code 3'b001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_pi | input | BSR_LEN | Pin values captured by sample/preload |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` (0 = high impedance) |
| bsr_po | output | BSR_LEN | Boundary update register contents |

## Verification
The bench enters the five-ones reset from the middle of a DR shift, from an IR pause, from an Exit2 state and from Shift-IR. Each time it first loads a non-identity instruction. A controller that missed one of these arcs, or a reset that left the instruction alone, would then read back a one-bit pass-through chain instead of the identity word. It feeds an identity value with bit 0 cleared and an unused instruction code. A missing forced bit or a decode hole would show up as a wrong readout or a wrong chain length. It inspects `bsr_po` from Pause-DR, between shifting and update, and after a pass-through scan. An update register that followed the shift stages, or that was written under the wrong instruction, would change there. A reference model compares `tdo_oe` and `tdo` on every falling-edge half period. An enable that was left on outside shift states, or data taken from the wrong end of a register, fails at once.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'h0,
    ST_IDLE     = 4'h1,
    ST_DR_SEL   = 4'h2,
    ST_DR_CAP   = 4'h3,
    ST_DR_SHIFT = 4'h4,
    ST_DR_EX1   = 4'h5,
    ST_DR_PAUSE = 4'h6,
    ST_DR_EX2   = 4'h7,
    ST_DR_UPD   = 4'h8,
    ST_IR_SEL   = 4'h9,
    ST_IR_CAP   = 4'hA,
    ST_IR_SHIFT = 4'hB,
    ST_IR_EX1   = 4'hC,
    ST_IR_PAUSE = 4'hD,
    ST_IR_EX2   = 4'hE,
    ST_IR_UPD   = 4'hF
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  localparam logic [1:0] IR_CAPTURE_TAG = 2'b01;

  typedef enum logic [1:0] {
    DR_BYPASS   = 2'd0,
    DR_IDENT    = 2'd1,
    DR_BOUNDARY = 2'd2
  } dr_sel_e;

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    dr_sel_e sel;
    case (op)
      OP_IDCODE: sel = DR_IDENT;
      OP_SAMPLE: sel = DR_BOUNDARY;
      default:   sel = DR_BYPASS;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   state_d = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: state_d = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: state_d = tms ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   state_d = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: state_d = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: state_d = tms ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RESET;
    end else begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] instr
);

  logic            cap_en;
  logic            sh_en;
  logic            upd_en;
  logic            force_id;
  logic [IR_W-1:0] ir_sh_d;

  assign cap_en   = (state == ST_IR_CAP);
  assign sh_en    = (state == ST_IR_SHIFT);
  assign upd_en   = (state == ST_IR_UPD);
  assign force_id = (state == ST_RESET);

  always_comb begin
    ir_sh_d = ir_sh;
    if (cap_en) begin
      ir_sh_d = {{(IR_W-2){1'b0}}, IR_CAPTURE_TAG};
    end else if (sh_en) begin
      ir_sh_d = {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh <= '0;
    end else if (cap_en || sh_en) begin
      ir_sh <= ir_sh_d;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      instr <= OP_IDCODE;
    end else if (force_id) begin
      instr <= OP_IDCODE;
    end else if (upd_en) begin
      instr <= ir_sh;
    end
  end

endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_port_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  logic [IR_W-1:0]    instr,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsr_pi,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_po
);

  localparam int          ID_W   = 32;
  localparam logic [31:0] ID_CAP = {ID_CODE[31:1], 1'b1};

  dr_sel_e sel;
  logic    cap_st;
  logic    sh_st;
  logic    upd_st;

  assign sel    = decode_op(instr);
  assign cap_st = (state == ST_DR_CAP);
  assign sh_st  = (state == ST_DR_SHIFT);
  assign upd_st = (state == ST_DR_UPD);

  // pass-through register
  logic byp_cap_en, byp_sh_en, byp_q;
  assign byp_cap_en = cap_st && (sel == DR_BYPASS);
  assign byp_sh_en  = sh_st  && (sel == DR_BYPASS);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (byp_cap_en) begin
      byp_q <= 1'b0;
    end else if (byp_sh_en) begin
      byp_q <= tdi;
    end
  end

  // identity register
  logic            id_cap_en, id_sh_en;
  logic [ID_W-1:0] id_q;
  assign id_cap_en = cap_st && (sel == DR_IDENT);
  assign id_sh_en  = sh_st  && (sel == DR_IDENT);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_cap_en) begin
      id_q <= ID_CAP;
    end else if (id_sh_en) begin
      id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  // boundary register, one cell per pin
  logic               bsr_cap_en, bsr_sh_en, bsr_upd_en;
  logic [BSR_LEN-1:0] bsr_sh;
  logic [BSR_LEN-1:0] cell_in;
  assign bsr_cap_en = cap_st && (sel == DR_BOUNDARY);
  assign bsr_sh_en  = sh_st  && (sel == DR_BOUNDARY);
  assign bsr_upd_en = upd_st && (sel == DR_BOUNDARY);

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic sh_q;
    logic po_q;

    if (i == BSR_LEN - 1) begin : g_top
      assign cell_in[i] = tdi;
    end else begin : g_mid
      assign cell_in[i] = bsr_sh[i+1];
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= 1'b0;
      end else if (bsr_cap_en) begin
        sh_q <= bsr_pi[i];
      end else if (bsr_sh_en) begin
        sh_q <= cell_in[i];
      end
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        po_q <= 1'b0;
      end else if (bsr_upd_en) begin
        po_q <= sh_q;
      end
    end

    assign bsr_sh[i] = sh_q;
    assign bsr_po[i] = po_q;
  end

  always_comb begin
    case (sel)
      DR_IDENT:    dr_lsb = id_q[0];
      DR_BOUNDARY: dr_lsb = bsr_sh[0];
      default:     dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h2C71_4A63
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsr_pi,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BSR_LEN-1:0] bsr_po
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_n = rst_sync[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] instr;
  logic            dr_lsb;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  scan_ir u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .state (state),
    .tdi   (tdi),
    .ir_sh (ir_sh),
    .instr (instr)
  );

  scan_dr #(
    .BSR_LEN (BSR_LEN),
    .ID_CODE (ID_CODE)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .instr  (instr),
    .tdi    (tdi),
    .bsr_pi (bsr_pi),
    .dr_lsb (dr_lsb),
    .bsr_po (bsr_po)
  );

  // falling-edge output stage
  logic in_shift;
  logic tdo_d;

  assign in_shift = (state == ST_DR_SHIFT) || (state == ST_IR_SHIFT);
  assign tdo_d    = (state == ST_IR_SHIFT) ? ir_sh[0] : dr_lsb;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= in_shift;
    end
  end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int BSR_LEN = 8
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    instr,
  input logic [IR_W-1:0]    ir_sh,
  input logic               tdo_oe,
  input logic [BSR_LEN-1:0] bsr_po
);

  logic [2:0] ones;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ones <= 3'd0;
    end else if (!tms) begin
      ones <= 3'd0;
    end else if (ones != 3'd7) begin
      ones <= ones + 3'd1;
    end
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (ones >= 3'd5) |-> (state == ST_RESET)); // R2

  AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> ((state == ST_DR_SHIFT) || (state == ST_IR_SHIFT))); // R3

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == ST_DR_SHIFT) || (state == ST_IR_SHIFT)) |-> tdo_oe); // R3

  AST_IR_CAPTURE_TAG: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_CAP) |=> (ir_sh[1:0] == 2'b01)); // R4

  AST_INSTR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    ((state != ST_IR_UPD) && (state != ST_RESET)) |=> $stable(instr)); // R5

  AST_BSR_PO_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_DR_UPD) |=> $stable(bsr_po)); // R8

  AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (instr == OP_IDCODE)); // R10

endmodule

bind scan_port scan_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck    (tck),
  .rst_n  (rst_n),
  .tms    (tms),
  .state  (state),
  .instr  (instr),
  .ir_sh  (ir_sh),
  .tdo_oe (tdo_oe),
  .bsr_po (bsr_po)
);

// File: tb/scan_port_bench.sv
`timescale 1ns/1ps
module scan_port_bench;

  localparam int          BSR   = 8;
  localparam logic [31:0] ID_IN  = 32'h4B1D_2A6E;
  localparam logic [31:0] ID_EXP = 32'h4B1D_2A6F;

  logic           tck = 1'b0;
  logic           por_n;
  logic           tms;
  logic           tdi;
  logic [BSR-1:0] bsr_pi;
  logic           tdo;
  logic           tdo_oe;
  logic [BSR-1:0] bsr_po;

  int checks = 0;
  int errors = 0;

  always #5 tck = ~tck;

  scan_port #(.BSR_LEN(BSR), .ID_CODE(ID_IN)) u_scan_port (
    .tck    (tck),
    .por_n  (por_n),
    .tms    (tms),
    .tdi    (tdi),
    .bsr_pi (bsr_pi),
    .tdo    (tdo),
    .tdo_oe (tdo_oe),
    .bsr_po (bsr_po)
  );

  // ---------------- behavioural reference ----------------
  localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3;
  localparam int S_SHD = 4,  S_E1D = 5,  S_PD  = 6,  S_E2D = 7;
  localparam int S_UD  = 8,  S_SIR = 9,  S_CIR = 10, S_SHI = 11;
  localparam int S_E1I = 12, S_PI  = 13, S_E2I = 14, S_UI  = 15;

  function automatic int nxt(input int s, input bit m);
    case (s)
      S_TLR: return m ? S_TLR : S_RTI;
      S_RTI: return m ? S_SDR : S_RTI;
      S_SDR: return m ? S_SIR : S_CDR;
      S_CDR: return m ? S_E1D : S_SHD;
      S_SHD: return m ? S_E1D : S_SHD;
      S_E1D: return m ? S_UD  : S_PD;
      S_PD:  return m ? S_E2D : S_PD;
      S_E2D: return m ? S_UD  : S_SHD;
      S_UD:  return m ? S_SDR : S_RTI;
      S_SIR: return m ? S_TLR : S_CIR;
      S_CIR: return m ? S_E1I : S_SHI;
      S_SHI: return m ? S_E1I : S_SHI;
      S_E1I: return m ? S_UI  : S_PI;
      S_PI:  return m ? S_E2I : S_PI;
      S_E2I: return m ? S_UI  : S_SHI;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  int       ms;
  bit [2:0] mir;
  bit       irq[$];
  bit       drq[$];
  bit       exp_oe;
  bit       exp_do;

  always @(posedge tck) begin
    if (!por_n) begin
      ms  = S_TLR;
      mir = 3'b001;
      irq.delete();
      drq.delete();
    end else begin
      case (ms)
        S_TLR: mir = 3'b001;
        S_CIR: begin irq.delete(); irq.push_back(1'b1); irq.push_back(1'b0); irq.push_back(1'b0); end
        S_SHI: begin void'(irq.pop_front()); irq.push_back(tdi); end
        S_UI:  mir = {irq[2], irq[1], irq[0]};
        S_CDR: begin
          drq.delete();
          if (mir == 3'b001) begin
            for (int i = 0; i < 32; i++) drq.push_back(ID_EXP[i]);
          end else if (mir == 3'b100) begin
            for (int i = 0; i < BSR; i++) drq.push_back(bsr_pi[i]);
          end else begin
            drq.push_back(1'b0);
          end
        end
        S_SHD: begin void'(drq.pop_front()); drq.push_back(tdi); end
        default: ;
      endcase
      ms = nxt(ms, tms);
    end
  end

  always @(negedge tck) begin
    exp_oe = (ms == S_SHD) || (ms == S_SHI);
    if (ms == S_SHI) exp_do = irq[0];
    else if (ms == S_SHD) exp_do = drq[0];
    #3;
    if (por_n) begin
      checks++;
      if (tdo_oe !== exp_oe) begin
        errors++;
        $display("FAIL R3 tdo_oe act=%0b exp=%0b t=%0t", tdo_oe, exp_oe, $time);
      end
      if (exp_oe) begin
        checks++;
        if (tdo !== exp_do) begin
          errors++;
          $display("FAIL R9 tdo act=%0b exp=%0b t=%0t", tdo, exp_do, $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit m, input bit d, output bit o);
    @(negedge tck);
    #2;
    tms = m;
    tdi = d;
    #2;
    o = tdo;
    @(posedge tck);
  endtask

  task automatic walk(input bit m);
    bit o;
    step(m, 1'b0, o);
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap);
    bit o;
    walk(1); walk(1); walk(0); walk(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o);
      cap[i] = o;
    end
    walk(1); walk(0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din,
                         output logic [63:0] dout, input bit pause);
    bit o;
    dout = '0;
    walk(1); walk(0); walk(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    if (pause) begin
      walk(0);
    end else begin
      walk(1); walk(0);
    end
  endtask

  task automatic leave_pause();
    walk(1); walk(1); walk(0);
  endtask

  task automatic five_ones_from(input int len, input logic [7:0] path, input string where);
    logic [2:0]  cap;
    logic [63:0] q;
    ir_scan(3'b111, cap);
    for (int i = 0; i < len; i++) walk(path[i]);
    for (int i = 0; i < 5; i++) walk(1);
    #1;
    chk({"R2 oe after five ones from ", where}, {63'b0, tdo_oe}, 64'd0);
    walk(0);
    dr_scan(32, 64'd0, q, 1'b0);
    chk({"R2 R10 idcode after five ones from ", where}, q, {32'b0, ID_EXP});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [2:0]  cap;
    logic [63:0] q;
    por_n  = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b1;
    bsr_pi = 8'hA5;
    #23;
    chk("R1 oe in reset", {63'b0, tdo_oe}, 64'd0);
    por_n = 1'b1;
    for (int i = 0; i < 4; i++) walk(1);
    #1;
    chk("R1 oe after reset", {63'b0, tdo_oe}, 64'd0);
    chk("R1 bsr_po after reset", {56'b0, bsr_po}, 64'd0);
    walk(0);

    dr_scan(32, 64'd0, q, 1'b0);
    chk("R1 R7 R10 idcode readout", q, {32'b0, ID_EXP});

    ir_scan(3'b111, cap);
    chk("R4 ir capture pattern", {61'b0, cap}, 64'd1);

    dr_scan(8, 64'hB2, q, 1'b0);
    chk("R6 R9 bypass delay", q, 64'h64);

    ir_scan(3'b010, cap);
    dr_scan(4, 64'hD, q, 1'b0);
    chk("R5 unused code acts as bypass", q, 64'hA);

    ir_scan(3'b001, cap);
    chk("R4 ir capture second scan", {61'b0, cap}, 64'd1);
    dr_scan(32, 64'h0, q, 1'b0);
    chk("R5 R7 idcode by instruction", q, {32'b0, ID_EXP});

    ir_scan(3'b100, cap);
    bsr_pi = 8'h3C;
    dr_scan(8, 64'hC6, q, 1'b1);
    chk("R8 sample captures pins", q, 64'h3C);
    #1;
    chk("R8 bsr_po holds before update", {56'b0, bsr_po}, 64'd0);
    leave_pause();
    #1;
    chk("R8 bsr_po after update", {56'b0, bsr_po}, 64'hC6);

    bsr_pi = 8'h5A;
    dr_scan(8, 64'h00, q, 1'b0);
    chk("R8 second sample", q, 64'h5A);
    #1;
    chk("R8 second update", {56'b0, bsr_po}, 64'h00);

    dr_scan(8, 64'h81, q, 1'b0);
    #1;
    chk("R8 preload update", {56'b0, bsr_po}, 64'h81);

    ir_scan(3'b111, cap);
    dr_scan(8, 64'hFF, q, 1'b0);
    #1;
    chk("R8 bypass leaves bsr_po", {56'b0, bsr_po}, 64'h81);

    five_ones_from(3, 8'b001, "shift-dr");
    five_ones_from(5, 8'b01011, "pause-ir");
    five_ones_from(5, 8'b10101, "exit2-dr");
    five_ones_from(4, 8'b0011, "shift-ir");

    walk(0);
    walk(0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule